// File: doc/BRIEF.md
# Dual-Bank External RAM Address Translator

This block turns a CPU data address that falls inside a 4 MB external-RAM window (0x3F80_0000 up to 0x3FBF_FFFF) into a 23-bit physical external-RAM address. The window is cut into 128 pages of 32 KB each. Every page has one mapping entry in each of two banks, called left and right. An entry holds an 8-bit physical page number and a flag that marks the entry as not mapped.

A 2-bit mode input chooses which bank answers each lookup. The bank can follow the requesting CPU, the lower or upper half of the window, or alternating 32-byte chunks. Software fills the banks through a simple write port. The same bank and index select a combinational read-back path.

A lookup returns one cycle after the request. The response is one of three outcomes: a hit with a physical address, a fault because the chosen entry is not mapped, or neither because the address lies outside the window.

Top module: `xram_xlate`

## Requirements
- R1: While reset is asserted and right after it, rsp_valid, rsp_hit and rsp_fault are 0 and rsp_paddr is 0. Every entry in both banks reads back as 0x0000_0100 (not mapped), so an in-window lookup made before any write faults.
- R2: A request whose address bits 31:22 differ from 0x0FE lies outside the window. It gives rsp_valid=1 with rsp_hit=0, rsp_fault=0 and rsp_paddr=0.
- R3: In mode 2'b00, a request with req_cpu=0 uses the left bank and one with req_cpu=1 uses the right bank, anywhere in the window.
- R4: In mode 2'b01, req_cpu has no effect. Address bit 21 = 0 (the lower 2 MB) uses the left bank and bit 21 = 1 uses the right bank.
- R5: In mode 2'b10, req_cpu has no effect. Address bit 5 = 0 (even 32-byte chunk) uses the left bank and bit 5 = 1 uses the right bank.
- R6: Mode 2'b11 selects the bank exactly as mode 2'b00 does.
- R7: The entry index is address bits 21:15. On a hit the physical address is {entry bits 7:0, address bits 14:0}.
- R8: An entry with bit 8 = 1 is not mapped. A lookup that selects it gives rsp_fault=1, rsp_hit=0 and rsp_paddr=0. rsp_hit and rsp_fault are never both 1.
- R9: rsp_valid, rsp_hit, rsp_fault and rsp_paddr reflect the request of the previous clock cycle. When there is no request, rsp_valid is 0. When the response is not a hit, rsp_paddr is 0.
- R10: When cfg_we=1, cfg_wdata bits 8:0 are stored into entry cfg_idx of the bank named by cfg_bank (0 = left, 1 = right), and the upper data bits are dropped. cfg_rdata shows that entry with bits 31:9 reading 0. A lookup in the same cycle as the write still sees the old entry; the new entry is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the request |
| req_cpu | input | 1 | Requesting CPU (0 or 1) |
| req_mode | input | 2 | Bank selection mode |
| cfg_we | input | 1 | Entry write enable |
| cfg_bank | input | 1 | Bank for write and read-back (0 left, 1 right) |
| cfg_idx | input | 7 | Entry index for write and read-back |
| cfg_wdata | input | 32 | Entry write data |
| cfg_rdata | output | 32 | Read-back of the addressed entry |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Chosen entry is not mapped |
| rsp_paddr | output | 23 | Physical address on a hit, else 0 |

## Verification
The properties take for granted that every request and configuration input has a known 0/1 value whenever reset is released. They also assume that reset leaves in step with the clock, so the first sampled response after reset is a true successor of a request sampled during reset. The bench keeps within these limits by driving every input only on the falling edge and by holding all request and write inputs at zero throughout reset. It also releases reset on a falling edge, and its random phase draws only fully defined addresses, modes and write data.

// File: rtl/xram_xlate_pkg.sv
package xram_xlate_pkg;

  localparam int unsigned IDX_W   = 7;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned OFF_W   = 15;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned WIN_LSB = IDX_W + OFF_W;
  localparam int unsigned PADDR_W = PAGE_W + OFF_W;
  localparam int unsigned ENT_W   = PAGE_W + 1;
  localparam int unsigned NBANK   = 2;

  typedef enum logic [1:0] {
    MAP_PER_CPU = 2'b00,
    MAP_HALVES  = 2'b01,
    MAP_STRIPE  = 2'b10,
    MAP_ALIAS   = 2'b11
  } map_mode_e;

  typedef struct packed {
    logic              absent;
    logic [PAGE_W-1:0] page;
  } map_entry_t;

  localparam map_entry_t ENTRY_RST = '{absent: 1'b1, page: '0};

endpackage

// File: rtl/xram_map_bank.sv
module xram_map_bank
  import xram_xlate_pkg::*;
#(
  parameter int unsigned NUM = ENTRIES,
  parameter int unsigned IW  = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  map_entry_t    wr_entry,
  input  logic [IW-1:0] lk_idx,
  output map_entry_t    lk_entry,
  input  logic [IW-1:0] rd_idx,
  output map_entry_t    rd_entry
);

  map_entry_t ent_q [NUM];

  // One register per entry; a decoded write enable acts as its clock enable.
  for (genvar e = 0; e < NUM; e++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= ENTRY_RST;
      end else if (ent_en) begin
        ent_q[e] <= wr_entry;
      end
    end
  end

  assign lk_entry = ent_q[lk_idx];
  assign rd_entry = ent_q[rd_idx];

endmodule

// File: rtl/xram_bank_sel.sv
module xram_bank_sel
  import xram_xlate_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h3F80_0000
) (
  input  logic             [31:0] vaddr,
  input  logic                    cpu_id,
  input  map_mode_e               mode,
  output logic                    in_win,
  output logic                    pick_right,
  output logic [IDX_W-1:0]        idx,
  output logic [OFF_W-1:0]        ofs
);

  localparam int unsigned HALF_BIT  = WIN_LSB - 1;
  localparam int unsigned CHUNK_BIT = 5;

  always_comb begin
    in_win = (vaddr[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
    idx    = vaddr[WIN_LSB-1:OFF_W];
    ofs    = vaddr[OFF_W-1:0];
    unique case (mode)
      MAP_HALVES: pick_right = vaddr[HALF_BIT];
      MAP_STRIPE: pick_right = vaddr[CHUNK_BIT];
      MAP_PER_CPU,
      MAP_ALIAS:  pick_right = cpu_id;
      default:    pick_right = cpu_id;
    endcase
  end

endmodule

// File: rtl/xram_xlate.sv
module xram_xlate
  import xram_xlate_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h3F80_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_vaddr,
  input  logic                 req_cpu,
  input  logic [1:0]           req_mode,
  input  logic                 cfg_we,
  input  logic                 cfg_bank,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_fault,
  output logic [PADDR_W-1:0]   rsp_paddr
);

  logic              in_win;
  logic              pick_right;
  logic [IDX_W-1:0]  lk_idx;
  logic [OFF_W-1:0]  lk_ofs;
  map_entry_t        wr_entry;
  map_entry_t        lk_ent [NBANK];
  map_entry_t        rd_ent [NBANK];
  map_entry_t        chosen;

  logic              valid_d, hit_d, fault_d;
  logic [PADDR_W-1:0] paddr_d;

  assign wr_entry = map_entry_t'(cfg_wdata[ENT_W-1:0]);

  xram_bank_sel #(.WIN_BASE(WIN_BASE)) u_sel (
    .vaddr      (req_vaddr),
    .cpu_id     (req_cpu),
    .mode       (map_mode_e'(req_mode)),
    .in_win     (in_win),
    .pick_right (pick_right),
    .idx        (lk_idx),
    .ofs        (lk_ofs)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = cfg_we && (cfg_bank == 1'(b));

    xram_map_bank #(.NUM(ENTRIES), .IW(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_we),
      .wr_idx   (cfg_idx),
      .wr_entry (wr_entry),
      .lk_idx   (lk_idx),
      .lk_entry (lk_ent[b]),
      .rd_idx   (cfg_idx),
      .rd_entry (rd_ent[b])
    );
  end

  assign chosen    = pick_right ? lk_ent[1] : lk_ent[0];
  assign cfg_rdata = {{(32-ENT_W){1'b0}}, rd_ent[cfg_bank]};

  // Next-state of the response stage.
  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && in_win && !chosen.absent;
    fault_d = req_valid && in_win &&  chosen.absent;
    paddr_d = hit_d ? {chosen.page, lk_ofs} : '0;
  end

  // Response register stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_fault <= fault_d;
      rsp_paddr <= paddr_d;
    end
  end

endmodule

// File: rtl/xram_xlate_chk.sv
module xram_xlate_chk
  import xram_xlate_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h3F80_0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_vaddr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PADDR_W-1:0] rsp_paddr
);

  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R8
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  // R9
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || rsp_fault) |-> rsp_valid);

  // R2
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && ($past(req_vaddr[31:WIN_LSB]) != WIN_BASE[31:WIN_LSB]))
      |-> (!rsp_hit && !rsp_fault));

  // R7
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R9
  paddr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0));

endmodule

bind xram_xlate xram_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr)
);

// File: tb/xram_xlate_test.sv
module xram_xlate_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_cpu;
  logic [1:0]  req_mode;
  logic        cfg_we;
  logic        cfg_bank;
  logic [6:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [22:0] rsp_paddr;

  int tests = 0;
  int fails = 0;

  // Behavioural reference state
  logic [8:0]  model [2][128];
  logic        e_valid, e_hit, e_fault;
  logic [22:0] e_paddr;
  string       prev_tag;

  xram_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_cpu(req_cpu), .req_mode(req_mode), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b01:   return "R4";
      2'b10:   return "R5";
      2'b11:   return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] va(input int idx, input int ofs);
    return 32'h3F80_0000 + (idx << 15) + ofs;
  endfunction

  task automatic check_out(input string tag);
    tests++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_fault !== e_fault || rsp_paddr !== e_paddr) begin
      fails++;
      $display("FAIL %s: actual v=%0b h=%0b f=%0b pa=%h expected v=%0b h=%0b f=%0b pa=%h",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, e_valid, e_hit, e_fault, e_paddr);
    end
  endtask

  task automatic check_rd(input string tag);
    logic [31:0] exp_rd;
    exp_rd = {23'd0, model[cfg_bank][cfg_idx]};
    tests++;
    if (cfg_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s: readback actual=%h expected=%h", tag, cfg_rdata, exp_rd);
    end
  endtask

  // One clock of stimulus: check last cycle's results, drive, predict.
  task automatic cyc(input logic rv, input logic [31:0] a, input logic cid,
                     input logic [1:0] md, input logic we, input logic wb,
                     input logic [6:0] wi, input logic [31:0] wd, input string tag);
    logic       right;
    logic [8:0] ent;
    string      t;
    @(negedge clk);
    check_out(prev_tag);
    check_rd("R10");
    req_valid = rv; req_vaddr = a; req_cpu = cid; req_mode = md;
    cfg_we = we; cfg_bank = wb; cfg_idx = wi; cfg_wdata = wd;
    // Reference prediction uses entries as they were before this cycle's write (R10)
    case (md)
      2'b01:   right = a[21];
      2'b10:   right = a[5];
      default: right = cid;
    endcase
    ent = model[right][a[21:15]];
    t = tag;
    e_valid = rv; e_hit = 1'b0; e_fault = 1'b0; e_paddr = '0;
    if (rv && a[31:22] == 10'h0FE) begin
      if (ent[8]) begin
        e_fault = 1'b1;
        if (t == "") t = "R8";
      end else begin
        e_hit = 1'b1;
        e_paddr = {ent[7:0], a[14:0]};
        if (t == "") t = mode_tag(md);
      end
    end else if (rv && t == "") begin
      t = "R2";
    end else if (t == "") begin
      t = "R9";
    end
    if (we) model[wb][wi] = wd[8:0];
    prev_tag = t;
  endtask

  task automatic wr(input logic b, input int i, input logic [31:0] d);
    cyc(1'b0, 32'd0, 1'b0, 2'b00, 1'b1, b, 7'(i), d, "R9");
  endtask

  task automatic look(input logic [31:0] a, input logic cid, input logic [1:0] md, input string tag);
    cyc(1'b1, a, cid, md, 1'b0, 1'b0, 7'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL R9: watchdog expired, actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 128; i++) model[b][i] = 9'h100;
    rst_n = 1'b0; req_valid = 0; req_vaddr = 0; req_cpu = 0; req_mode = 0;
    cfg_we = 0; cfg_bank = 0; cfg_idx = 0; cfg_wdata = 0;
    e_valid = 0; e_hit = 0; e_fault = 0; e_paddr = '0; prev_tag = "R1";

    // R1: reset state, outputs and read-back of several entries
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfg_bank = k[0]; cfg_idx = 7'(k * 37);
      #1;
      check_out("R1");
      check_rd("R1");
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: lookups before programming fault
    look(va(5, 16'h0100), 1'b0, 2'b00, "R1");
    look(va(90, 16'h0200), 1'b1, 2'b01, "R1");

    // R10: program every entry; upper write bits are dropped
    for (int i = 0; i < 128; i++) begin
      wr(1'b0, i, 32'hABCD_E000 | (i + 1));
      wr(1'b1, i, 32'h0000_0080 | i);
    end

    // R3: per-CPU mode
    look(va(5, 16'h1234), 1'b0, 2'b00, "R3");
    look(va(5, 16'h1234), 1'b1, 2'b00, "R3");
    look(va(127, 16'h7FFF), 1'b1, 2'b00, "R3");
    // R4: halves mode, cpu ignored
    look(va(5, 16'h0040), 1'b1, 2'b01, "R4");
    look(va(70, 16'h0040), 1'b0, 2'b01, "R4");
    look(va(63, 16'h7FE0), 1'b0, 2'b01, "R4");
    look(va(64, 16'h0000), 1'b1, 2'b01, "R4");
    // R5: 32-byte stripes, cpu ignored
    look(va(9, 16'h001F), 1'b1, 2'b10, "R5");
    look(va(9, 16'h0020), 1'b0, 2'b10, "R5");
    look(va(9, 16'h0040), 1'b1, 2'b10, "R5");
    // R6: mode 3 aliases per-CPU
    look(va(12, 16'h0333), 1'b1, 2'b11, "R6");
    look(va(12, 16'h0333), 1'b0, 2'b11, "R6");
    // R7: index and offset edges
    look(va(0, 16'h0000), 1'b0, 2'b00, "R7");
    look(va(127, 16'h7FFF), 1'b0, 2'b00, "R7");
    // R2: outside the window
    look(32'h3FC0_0000, 1'b0, 2'b00, "R2");
    look(32'h3F7F_FFFF, 1'b1, 2'b01, "R2");
    look(32'h0000_0000, 1'b0, 2'b10, "R2");
    // R8: unmapped entry faults
    wr(1'b0, 3, 32'h0000_0133);
    look(va(3, 16'h0010), 1'b0, 2'b00, "R8");
    look(va(3, 16'h0030), 1'b0, 2'b10, "R5");
    // R10: same-cycle write sees old entry, next cycle sees new
    cyc(1'b1, va(10, 16'h0444), 1'b0, 2'b00, 1'b1, 1'b0, 7'd10, 32'h0000_00EE, "R10");
    look(va(10, 16'h0444), 1'b0, 2'b00, "R10");
    // R10: write to the other bank leaves this one untouched
    wr(1'b1, 10, 32'h0000_0111);
    look(va(10, 16'h0444), 1'b0, 2'b00, "R10");
    look(va(10, 16'h0444), 1'b1, 2'b00, "R8");
    // R9: idle cycles
    cyc(1'b0, va(20, 0), 1'b0, 2'b00, 1'b0, 1'b0, 7'd0, 32'd0, "R9");
    cyc(1'b0, 32'd0, 1'b1, 2'b01, 1'b0, 1'b1, 7'd77, 32'd0, "R9");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, d;
      a = {10'h0FE, 22'($urandom)};
      if ($urandom_range(0, 9) == 0) a = $urandom;
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[8] = 1'b0;
      cyc($urandom_range(0, 4) != 0, a, 1'($urandom), 2'($urandom),
          $urandom_range(0, 5) == 0, 1'($urandom), 7'($urandom), d, "");
    end
    cyc(1'b0, 32'd0, 1'b0, 2'b00, 1'b0, 1'b0, 7'd0, 32'd0, "R9");
    @(negedge clk);
    check_out(prev_tag);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule